// File: doc/BRIEF.md
# Ring Oscillator Array Scan Measurer

This block maps how oscillator speed varies across a die. It steps through a grid of ring-oscillator tiles and enables only one tile at a time. The selected tile's output goes to a single shared edge counter, which counts the tile's rising edges over a programmable window of reference-clock cycles. A sweep makes two passes over the grid. The first pass runs from tile 0 up to the last tile, and the second pass runs from the last tile back down to tile 0. The count from the first pass is kept in a small per-tile store. When the tile is measured again in the second pass, the two counts are averaged with round-half-up and the result is sent out, tagged with the tile's row and column.

A single token in a shift chain selects the tile. The chain shifts towards higher indices during the first pass and towards lower indices during the second. Each time the token lands on a tile, a settle period runs before the count window opens. This gives time for the newly selected oscillator and the synchroniser to reach steady state. A guard watches the chain on every cycle. If the chain does not hold exactly one token during a sweep, or holds any token while idle, the guard raises a sticky error flag. The error also switches off every oscillator enable and sends the sequencer back to idle.

Sequencer states: `ST_IDLE` goes to `ST_SETTLE` on `start`. `ST_SETTLE` goes to `ST_COUNT` after `SETTLE_CYC` cycles. `ST_COUNT` goes to `ST_LATCH` when the window ends. `ST_LATCH` goes to `ST_NEXT` in the first pass and to `ST_EMIT` in the second pass. `ST_EMIT` goes to `ST_NEXT` on `res_ready`. `ST_NEXT` goes back to `ST_SETTLE`, or to `ST_IDLE` after tile 0 of the second pass. An error forces `ST_IDLE` from any state.

Top module: `rosc_scan_meter`

## Requirements
- R1: After reset, `osc_en` is all zero and `res_valid`, `done` and `err` are low.
- R2: At most one bit of `osc_en` is ever high.
- R3: A sweep enables every tile exactly twice. The first pass runs in ascending index order and the second in descending order. Exactly `ROWS*COLS` results are emitted, in order from index `N-1` down to 0. Tile index `i` is tagged row `i / COLS` and column `i % COLS` (row-major).
- R4: A pass count equals the number of rising edges of the tile's oscillator inside a window of `window_cycles` reference cycles. `window_cycles` must be held while a sweep runs. A value of 0 acts as 1.
- R5: The reported count is `(first + second + 1) >> 1`, where first and second are the counts from the two passes.
- R6: A pass count saturates at `2^CNT_W - 1`.
- R7: While `res_valid` is high and `res_ready` is low, the result fields and `res_valid` hold steady.
- R8: `done` is low from the start of a sweep until the final result is accepted. It is high in the cycle after that acceptance and stays high until the next sweep starts. A `start` pulse during a sweep has no effect.
- R9: Each enable of a tile lasts exactly `SETTLE_CYC + window_cycles + 1` cycles, with `SETTLE_CYC` defaulting to 16.
- R10: `err` is sticky. While `err` is high, `osc_en` is zero. In a normal sweep `err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a two-pass sweep |
| window_cycles | input | WIN_W | Count window length in reference cycles |
| osc_in | input | ROWS*COLS | Raw oscillator outputs, one per tile, asynchronous |
| osc_en | output | ROWS*COLS | Oscillator enables, at most one high |
| res_valid | output | 1 | Averaged result available |
| res_ready | input | 1 | Downstream accepts the result |
| res_row | output | ROW_W | Row tag of the result |
| res_col | output | COL_W | Column tag of the result |
| res_count | output | CNT_W | Averaged edge count |
| done | output | 1 | Sweep complete |
| err | output | 1 | Sticky token-chain fault flag |

## Verification
Some behaviours are checked on every cycle: that at most one enable is high, that `err` is sticky and silences the enables, that a stalled result holds still, and that `done` never overlaps an enabled oscillator or a valid result. Other behaviours only the bench scenarios can show, because they need known oscillator rates. These are the exact edge counts, the round-half-up average of two different pass rates, saturation, the reverse result order with its row and column tags, the enable length per tile, and a start pulse ignored in mid-sweep.

// File: rtl/ros_pkg.sv
package ros_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_COUNT,
        ST_LATCH,
        ST_EMIT,
        ST_NEXT
    } ros_state_e;

    typedef enum logic {
        DIR_FWD,
        DIR_REV
    } ros_dir_e;

endpackage

// File: rtl/ros_token_chain.sv
module ros_token_chain #(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             clear,
    input  ros_pkg::ros_dir_e dir,
    output logic [N-1:0]     chain
);
    import ros_pkg::*;

    // Token shift register: enters at position 0, walks up or down.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (clear) begin
            chain <= '0;
        end else if (load) begin
            chain    <= '0;
            chain[0] <= 1'b1;
        end else if (shift) begin
            if (dir == DIR_FWD) chain <= chain << 1;
            else                chain <= chain >> 1;
        end
    end

endmodule

// File: rtl/ros_token_guard.sv
module ros_token_guard #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic [N-1:0] chain,
    output logic         err
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] ones;
    logic          bad;

    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++) begin
            ones = ones + CW'(chain[i]);
        end
    end

    // During a sweep exactly one token; while idle none at all.
    assign bad = active ? (ones != CW'(1)) : (ones != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   err <= 1'b0;
        else if (bad) err <= 1'b1;
    end

endmodule

// File: rtl/ros_edge_counter.sv
module ros_edge_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_sel,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] count
);
    logic sync1, sync2, sync3;
    logic rise;

    // Two-flop synchroniser plus one history flop for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
        end else begin
            sync1 <= osc_sel;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    assign rise = sync2 & ~sync3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en && rise && (count != '1)) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ros_pass_store.sv
module ros_pass_store #(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] new_count,
    output logic [CNT_W-1:0] avg
);
    logic [CNT_W-1:0] first_pass [N];
    logic [CNT_W:0]   sum;

    always_ff @(posedge clk) begin
        if (wr_en) first_pass[idx] <= new_count;
    end

    // Round half up: add one before dropping the low bit.
    assign sum = {1'b0, first_pass[idx]} + {1'b0, new_count} + (CNT_W + 1)'(1);
    assign avg = sum[CNT_W:1];

endmodule

// File: rtl/rosc_scan_meter.sv
module rosc_scan_meter #(
    parameter int ROWS       = 11,
    parameter int COLS       = 17,
    parameter int CNT_W      = 24,
    parameter int WIN_W      = 24,
    parameter int SETTLE_CYC = 16,
    localparam int N_TILES   = ROWS * COLS,
    localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W     = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIN_W-1:0]   window_cycles,
    input  logic [N_TILES-1:0] osc_in,
    output logic [N_TILES-1:0] osc_en,
    output logic               res_valid,
    input  logic               res_ready,
    output logic [ROW_W-1:0]   res_row,
    output logic [COL_W-1:0]   res_col,
    output logic [CNT_W-1:0]   res_count,
    output logic               done,
    output logic               err
);
    import ros_pkg::*;

    localparam int IDX_W = (N_TILES > 1) ? $clog2(N_TILES) : 1;
    localparam int SET_W = $clog2(SETTLE_CYC + 1);

    ros_state_e           state, state_nx;
    ros_dir_e             dir;
    logic [IDX_W-1:0]     idx;
    logic [ROW_W-1:0]     row;
    logic [COL_W-1:0]     col;
    logic [SET_W-1:0]     settle_cnt;
    logic [WIN_W-1:0]     win_cnt;
    logic                 done_r;
    logic [N_TILES-1:0]   chain;
    logic [CNT_W-1:0]     pass_count;
    logic [CNT_W-1:0]     avg_count;
    logic                 settle_end, window_end;
    logic                 at_turn, at_final;
    logic                 chain_load, chain_shift, chain_clear;
    logic                 en_phase;

    assign settle_end = (settle_cnt == SET_W'(SETTLE_CYC - 1));
    assign window_end = (({1'b0, win_cnt} + (WIN_W + 1)'(1)) >= {1'b0, window_cycles});
    assign at_turn    = (dir == DIR_FWD) && (idx == IDX_W'(N_TILES - 1));
    assign at_final   = (dir == DIR_REV) && (idx == '0);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- transitions ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)      state_nx = ST_SETTLE;
            ST_SETTLE: if (settle_end) state_nx = ST_COUNT;
            ST_COUNT:  if (window_end) state_nx = ST_LATCH;
            ST_LATCH:  state_nx = (dir == DIR_FWD) ? ST_NEXT : ST_EMIT;
            ST_EMIT:   if (res_ready)  state_nx = ST_NEXT;
            ST_NEXT:   state_nx = at_final ? ST_IDLE : ST_SETTLE;
            default:   state_nx = ST_IDLE;
        endcase
        if (err) state_nx = ST_IDLE;
    end

    // ---------------- position, timers, result registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir        <= DIR_FWD;
            idx        <= '0;
            row        <= '0;
            col        <= '0;
            settle_cnt <= '0;
            win_cnt    <= '0;
            done_r     <= 1'b0;
            res_row    <= '0;
            res_col    <= '0;
            res_count  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start && !err) begin
                        dir        <= DIR_FWD;
                        idx        <= '0;
                        row        <= '0;
                        col        <= '0;
                        settle_cnt <= '0;
                        done_r     <= 1'b0;
                    end
                end
                ST_SETTLE: begin
                    settle_cnt <= settle_cnt + SET_W'(1);
                    win_cnt    <= '0;
                end
                ST_COUNT: begin
                    win_cnt <= win_cnt + WIN_W'(1);
                end
                ST_LATCH: begin
                    if (dir == DIR_REV) begin
                        res_row   <= row;
                        res_col   <= col;
                        res_count <= avg_count;
                    end
                end
                ST_EMIT: begin
                    if (res_ready && at_final) done_r <= 1'b1;
                end
                ST_NEXT: begin
                    settle_cnt <= '0;
                    if (at_turn) begin
                        dir <= DIR_REV;
                    end else if (!at_final) begin
                        if (dir == DIR_FWD) begin
                            idx <= idx + IDX_W'(1);
                            if (col == COL_W'(COLS - 1)) begin
                                col <= '0;
                                row <= row + ROW_W'(1);
                            end else begin
                                col <= col + COL_W'(1);
                            end
                        end else begin
                            idx <= idx - IDX_W'(1);
                            if (col == '0) begin
                                col <= COL_W'(COLS - 1);
                                row <= row - ROW_W'(1);
                            end else begin
                                col <= col - COL_W'(1);
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs and datapath controls ----------------
    always_comb begin
        en_phase    = (state == ST_SETTLE) || (state == ST_COUNT) || (state == ST_LATCH);
        chain_load  = (state == ST_IDLE) && start && !err;
        chain_shift = (state == ST_NEXT) && !at_turn && !at_final;
        chain_clear = ((state == ST_NEXT) && at_final) || err;
        osc_en      = chain & {N_TILES{en_phase && !err}};
        res_valid   = (state == ST_EMIT);
        done        = done_r;
    end

    ros_token_chain #(.N(N_TILES)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (chain_load),
        .shift (chain_shift),
        .clear (chain_clear),
        .dir   (dir),
        .chain (chain)
    );

    ros_token_guard #(.N(N_TILES)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state != ST_IDLE),
        .chain  (chain),
        .err    (err)
    );

    ros_edge_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_sel (osc_in[idx]),
        .clr     (state == ST_SETTLE),
        .en      (state == ST_COUNT),
        .count   (pass_count)
    );

    ros_pass_store #(.N(N_TILES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .wr_en     ((state == ST_LATCH) && (dir == DIR_FWD)),
        .idx       (idx),
        .new_count (pass_count),
        .avg       (avg_count)
    );

endmodule

// File: rtl/ros_meter_checker.sv
module ros_meter_checker #(
    parameter int N     = 4,
    parameter int ROW_W = 1,
    parameter int COL_W = 1,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     osc_en,
    input logic             res_valid,
    input logic             res_ready,
    input logic [ROW_W-1:0] res_row,
    input logic [COL_W-1:0] res_col,
    input logic [CNT_W-1:0] res_count,
    input logic             done,
    input logic             err
);
    // R2
    a_r2_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(osc_en))
        else $error("more than one oscillator enabled");

    // R7
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_count)
                                       && $stable(res_row) && $stable(res_col)))
        else $error("result changed while stalled");

    // R10
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err)
        else $error("error flag cleared");

    // R10
    a_r10_err_silences: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> (osc_en == '0))
        else $error("oscillator enabled after error");

    // R8
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!res_valid && (osc_en == '0)))
        else $error("done overlaps activity");

endmodule

bind rosc_scan_meter ros_meter_checker #(
    .N(N_TILES), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_en    (osc_en),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_row   (res_row),
    .res_col   (res_col),
    .res_count (res_count),
    .done      (done),
    .err       (err)
);

// File: tb/sim_rosc_scan_meter.sv
module sim_rosc_scan_meter;
    localparam int CLK_P = 10;
    localparam int ROWS  = 2;
    localparam int COLS  = 3;
    localparam int N     = ROWS * COLS;
    localparam int CNT_W = 5;
    localparam int WIN_W = 12;
    localparam int SAT   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             res_ready = 1'b0;
    logic [WIN_W-1:0] win = WIN_W'(24);
    logic [N-1:0]     osc = '0;
    logic [N-1:0]     osc_en;
    logic             res_valid, done, err;
    logic [0:0]       res_row;
    logic [1:0]       res_col;
    logic [CNT_W-1:0] res_count;

    always #(CLK_P / 2) clk = ~clk;

    rosc_scan_meter #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W), .WIN_W(WIN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .window_cycles(win),
        .osc_in(osc), .osc_en(osc_en), .res_valid(res_valid), .res_ready(res_ready),
        .res_row(res_row), .res_col(res_col), .res_count(res_count),
        .done(done), .err(err)
    );

    int checks = 0;
    int errors = 0;
    int half_a [N];
    int half_b [N];
    int sweep_id = 0;
    int got_row [N];
    int got_col [N];
    int got_cnt [N];
    int nres;

    // oscillator model state, owned by the monitor block below
    int ep [N];
    int ph [N];
    int len_cur [N];
    int len_bad = 0;
    int multi_hot = 0;
    int seen_sweep = 0;
    logic [N-1:0] en_d = '0;

    always @(negedge clk) begin
        int h;
        if (seen_sweep != sweep_id) begin
            seen_sweep = sweep_id;
            len_bad = 0;
            multi_hot = 0;
            for (int t = 0; t < N; t++) ep[t] = 0;
        end
        if ($countones(osc_en) > 1) multi_hot++;
        for (int t = 0; t < N; t++) begin
            if (osc_en[t]) begin
                if (!en_d[t]) begin
                    ep[t]++;
                    ph[t] = 0;
                    len_cur[t] = 0;
                end
                len_cur[t]++;
                ph[t]++;
                h = (ep[t] <= 1) ? half_a[t] : half_b[t];
                if (h != 0 && ph[t] >= h) begin
                    osc[t] = ~osc[t];
                    ph[t] = 0;
                end
            end else if (en_d[t]) begin
                if (len_cur[t] != 16 + int'(win) + 1) len_bad++;
            end
            en_d[t] = osc_en[t];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_cnt(input int h);
        int c;
        if (h == 0) return 0;
        c = int'(win) / (2 * h);
        return (c > SAT) ? SAT : c;
    endfunction

    // Runs one sweep; collects results; checks hold under stall and done timing.
    task automatic run_sweep(input bit stall, input int pulse_at);
        int  cyc = 0;
        bit  held = 0;
        int  hr = 0, hc = 0, hn = 0;
        bit  pulsed = 0;
        sweep_id++;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nres = 0;
        while (nres < N && cyc < 20000) begin
            if (held) begin
                chk("R7 valid held", int'(res_valid), 1);
                chk("R7 count held", int'(res_count), hn);
                chk("R7 tag held", int'(res_row) * 8 + int'(res_col), hr * 8 + hc);
            end
            if (nres == pulse_at && !pulsed) begin
                start = 1'b1;
                pulsed = 1;
            end else begin
                start = 1'b0;
            end
            res_ready = stall ? ((cyc % 3) == 2) : 1'b1;
            if (nres < N - 1) chk("R8 done low in sweep", int'(done), 0);
            held = res_valid && !res_ready;
            hr = int'(res_row);
            hc = int'(res_col);
            hn = int'(res_count);
            if (res_valid && res_ready) begin
                got_row[nres] = int'(res_row);
                got_col[nres] = int'(res_col);
                got_cnt[nres] = int'(res_count);
                nres++;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        res_ready = 1'b0;
        chk("R8 done after last accept", int'(done), 1);
    endtask

    task automatic check_results(input string tag);
        chk("R3 result count", nres, N);
        for (int k = 0; k < N; k++) begin
            int i = N - 1 - k;
            chk("R3 row tag", got_row[k], i / COLS);
            chk("R3 col tag", got_col[k], i % COLS);
            chk({tag, " count"}, got_cnt[k],
                (exp_cnt(half_a[i]) + exp_cnt(half_b[i]) + 1) >> 1);
        end
        for (int t = 0; t < N; t++) chk("R3 two enables per tile", ep[t], 2);
        chk("R2 single enable", multi_hot, 0);
        chk("R9 enable length", len_bad, 0);
        chk("R10 no error", int'(err), 0);
    endtask

    task automatic t_reset();
        chk("R1 osc_en", int'(osc_en), 0);
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
    endtask

    task automatic t_basic();   // R4: exact counts, same rate both passes
        win = WIN_W'(24);
        half_a = '{1, 2, 3, 4, 6, 0};
        half_b = '{1, 2, 3, 4, 6, 0};
        run_sweep(1'b0, -1);
        check_results("R4");
    endtask

    task automatic t_average(); // R5 with R7 backpressure
        win = WIN_W'(24);
        half_a = '{1, 2, 3, 1, 6, 0};
        half_b = '{2, 3, 6, 4, 0, 1};
        run_sweep(1'b1, -1);
        check_results("R5");
    endtask

    task automatic t_saturate(); // R6
        win = WIN_W'(96);
        half_a = '{1, 1, 4, 1, 2, 1};
        half_b = '{1, 1, 4, 1, 2, 2};
        run_sweep(1'b0, -1);
        check_results("R6");
    endtask

    task automatic t_start_ignored(); // R8
        win = WIN_W'(24);
        half_a = '{2, 1, 3, 6, 4, 2};
        half_b = '{2, 1, 3, 6, 4, 2};
        run_sweep(1'b0, 2);
        check_results("R8");
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R8 idle after sweep", int'(osc_en), 0);
            chk("R8 done stays", int'(done), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_average();
        t_saturate();
        t_start_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule